// File: doc/BRIEF.md
# Host Channel Interrupt Unit

This block gathers the interrupt events of a bank of USB host channels. Each channel holds a 14-bit event status register and a 14-bit enable mask. A status bit is set whenever its event input pulses, and stays set until software writes a one to it. A per-channel mode input selects between normal operation and descriptor-based (scatter/gather) DMA operation. In normal operation every unmasked status bit raises the channel interrupt. In descriptor operation only a small fixed group of events can raise it, and the excessive-transaction-error event raises it even when its mask bit is clear. Every other event is still recorded, so software can read it when it services the channel-halted event.

The channel interrupts form a host-wide summary vector with one bit per channel. A summary enable mask, updated through separate set-bits and clear-bits writes, gates that vector into a single host interrupt. All writes go through one write port, selected by a 2-bit operation code and a channel index. A registered read port returns the status and mask of the selected channel.

Top module: `hc_irq_top`

## Requirements
- R1: After synchronous reset every status, channel mask, summary mask, channel interrupt, the host interrupt and both read outputs are zero.
- R2: Event bit positions: 0 transfer complete, 1 channel halted, 2 bus error, 3 STALL, 4 NAK, 5 ACK, 6 NYET, 7 transaction error, 8 babble, 9 frame overrun, 10 data toggle error, 11 buffer not available, 12 excessive transaction errors, 13 descriptor rollover. A one on an event input sets that status bit at the next clock edge.
- R3: The write with operation code 0 (status clear) clears exactly those status bits of channel `wr_chan` that are one in `wr_data[13:0]`. All other bits are unchanged.
- R4: An event that arrives in the same cycle as a clear of its own bit leaves the bit set.
- R5: In normal mode (`desc_mode` bit low), the channel interrupt is the OR over all 14 bits of status AND mask, registered one cycle after the status and mask values. Operation code 1 replaces the mask of `wr_chan` with `wr_data[13:0]`.
- R6: In descriptor mode (`desc_mode` bit high), only status bits 13, 12, 11, 1 and 0 can raise the channel interrupt.
- R7: In descriptor mode, status bit 12 raises the channel interrupt whatever its mask bit holds.
- R8: In descriptor mode, events outside the permitted group still set their status bits but never raise the channel interrupt.
- R9: `chan_sum_o` carries one interrupt bit per channel. `host_irq_o` is the OR of `chan_sum_o` AND the summary mask, registered one cycle later.
- R10: Operation code 2 sets the summary mask bits that are one in `wr_data[NCH-1:0]`. Operation code 3 clears them. Bits written as zero keep their value.
- R11: `rd_status_o` and `rd_mask_o` show, one cycle after `rd_chan`, the status and mask of that channel as they stood before the clock edge. Bits 31:14 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NCH*14 | Event pulses; channel c at bits [c*14 +: 14] |
| desc_mode_i | input | NCH | Per-channel descriptor DMA mode |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | 0 status clear, 1 mask write, 2 summary set, 3 summary clear |
| wr_chan | input | CW | Channel targeted by a status or mask write |
| wr_data | input | 32 | Write data |
| rd_chan | input | CW | Channel whose registers are read |
| rd_status_o | output | 32 | Registered status of the read channel |
| rd_mask_o | output | 32 | Registered mask of the read channel |
| chan_sum_o | output | NCH | Per-channel interrupt summary |
| host_irq_o | output | 1 | Host-wide channel interrupt |

## Verification
The bench aims at a clear and an event hitting the same bit in the same cycle. A design that gave the clear priority would lose the event. It drives events outside the permitted group in descriptor mode with every mask bit set, where a design that skipped the mode gating would raise a spurious interrupt. It raises the excessive-error event with a zero mask, where a design that kept that bit maskable would stay silent. It also mixes summary set and clear writes, where a plain overwrite would drop enables that were already set, and checks the upper read bits and the one-cycle read latency.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int NEV = 14;
  // events that may interrupt under descriptor DMA: 13,12,11,1,0
  localparam logic [NEV-1:0] DESC_ALLOW = 14'h3803;
  // excessive transaction error, never masked in descriptor mode
  localparam logic [NEV-1:0] DESC_FORCE = 14'h1000;

  typedef enum logic [1:0] {
    OP_STS_CLR = 2'd0,
    OP_MASK_WR = 2'd1,
    OP_SUM_SET = 2'd2,
    OP_SUM_CLR = 2'd3
  } wr_op_e;
endpackage

// File: rtl/hc_chan_cell.sv
module hc_chan_cell
  import hc_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] evt_i,
  input  logic           desc_i,
  input  logic           clr_we,
  input  logic           mask_we,
  input  logic [NEV-1:0] wdata,
  output logic [NEV-1:0] status_o,
  output logic [NEV-1:0] mask_o,
  output logic           irq_o
);
  logic [NEV-1:0] status_q, mask_q, clr_vec, eff_mask;
  logic           irq_q;

  assign clr_vec  = clr_we ? wdata : '0;
  assign eff_mask = desc_i ? ((mask_q & DESC_ALLOW) | DESC_FORCE) : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_vec) | evt_i;
      if (mask_we) mask_q <= wdata;
      irq_q <= |(status_q & eff_mask);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~evt_i) != '0) |=> ((status_q & $past(clr_vec & ~evt_i)) == '0)); // R3
  AST_DESC_FORCE: assert property (@(posedge clk) disable iff (rst)
    (desc_i && status_q[12]) |=> irq_q); // R7
  AST_DESC_GATE: assert property (@(posedge clk) disable iff (rst)
    (desc_i && ((status_q & DESC_ALLOW) == '0)) |=> !irq_q); // R6
endmodule

// File: rtl/hc_irq_summary.sv
module hc_irq_summary #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] sum_i,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] wdata,
  output logic           host_irq_o
);
  logic [NCH-1:0] smask_q;
  logic           host_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smask_q <= '0;
      host_q  <= 1'b0;
    end else begin
      if (set_we)      smask_q <= smask_q | wdata;
      else if (clr_we) smask_q <= smask_q & ~wdata;
      host_q <= |(sum_i & smask_q);
    end
  end

  assign host_irq_o = host_q;

  AST_HOST_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((sum_i & smask_q) != '0) |=> host_q); // R9
  AST_SMASK_SET: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((smask_q & $past(wdata)) == $past(wdata))); // R10
  AST_SMASK_CLR: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((smask_q & $past(wdata)) == '0)); // R10
endmodule

// File: rtl/hc_irq_top.sv
module hc_irq_top
  import hc_irq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH*NEV-1:0] evt_i,
  input  logic [NCH-1:0]     desc_mode_i,
  input  logic               wr_en,
  input  logic [1:0]         wr_op,
  input  logic [CW-1:0]      wr_chan,
  input  logic [31:0]        wr_data,
  input  logic [CW-1:0]      rd_chan,
  output logic [31:0]        rd_status_o,
  output logic [31:0]        rd_mask_o,
  output logic [NCH-1:0]     chan_sum_o,
  output logic               host_irq_o
);
  logic [NEV-1:0] sts_arr [NCH];
  logic [NEV-1:0] msk_arr [NCH];
  logic [NCH-1:0] irq_vec;
  logic [31:0]    rd_sts_q, rd_msk_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    hc_chan_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .evt_i   (evt_i[c*NEV +: NEV]),
      .desc_i  (desc_mode_i[c]),
      .clr_we  (wr_en && wr_op == OP_STS_CLR && wr_chan == CW'(c)),
      .mask_we (wr_en && wr_op == OP_MASK_WR && wr_chan == CW'(c)),
      .wdata   (wr_data[NEV-1:0]),
      .status_o(sts_arr[c]),
      .mask_o  (msk_arr[c]),
      .irq_o   (irq_vec[c])
    );
  end

  hc_irq_summary #(.NCH(NCH)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .sum_i     (irq_vec),
    .set_we    (wr_en && wr_op == OP_SUM_SET),
    .clr_we    (wr_en && wr_op == OP_SUM_CLR),
    .wdata     (wr_data[NCH-1:0]),
    .host_irq_o(host_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sts_q <= '0;
      rd_msk_q <= '0;
    end else begin
      rd_sts_q <= {{(32-NEV){1'b0}}, sts_arr[rd_chan]};
      rd_msk_q <= {{(32-NEV){1'b0}}, msk_arr[rd_chan]};
    end
  end

  assign rd_status_o = rd_sts_q;
  assign rd_mask_o   = rd_msk_q;
  assign chan_sum_o  = irq_vec;

  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_status_o[NEV-1:0] == $past(sts_arr[rd_chan]))); // R11
endmodule

// File: tb/tb_hc_irq_top.sv
`timescale 1ns/1ps
module tb_hc_irq_top;
  localparam int NCH = 8;
  localparam int NEV = 14;
  localparam int CW  = 3;
  localparam logic [NEV-1:0] ALLOW = 14'h3803;
  localparam logic [NEV-1:0] FORCE = 14'h1000;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH*NEV-1:0] evt_i = '0;
  logic [NCH-1:0] desc_mode_i = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_op = '0;
  logic [CW-1:0] wr_chan = '0, rd_chan = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_status_o, rd_mask_o;
  logic [NCH-1:0] chan_sum_o;
  logic host_irq_o;

  hc_irq_top #(.NCH(NCH)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [NEV-1:0] m_st [NCH];
  logic [NEV-1:0] m_mk [NCH];
  logic [NCH-1:0] m_smask, m_sum;
  logic m_host;
  logic [31:0] m_rd, m_rdm;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic chan_irq(input logic [NEV-1:0] st, input logic [NEV-1:0] mk,
                                    input logic desc);
    logic [NEV-1:0] eff = desc ? ((mk & ALLOW) | FORCE) : mk;
    return |(st & eff);
  endfunction

  // model one clock edge, then compare at the following negedge
  task automatic step(input string tag);
    logic [NCH-1:0] nsum;
    logic nhost;
    for (int c = 0; c < NCH; c++) nsum[c] = chan_irq(m_st[c], m_mk[c], desc_mode_i[c]);
    nhost = |(m_sum & m_smask);
    m_rd  = {18'b0, m_st[rd_chan]};
    m_rdm = {18'b0, m_mk[rd_chan]};
    for (int c = 0; c < NCH; c++) begin
      logic [NEV-1:0] clr = (wr_en && wr_op == 2'd0 && wr_chan == CW'(c)) ? wr_data[NEV-1:0] : '0;
      if (wr_en && wr_op == 2'd1 && wr_chan == CW'(c)) m_mk[c] = wr_data[NEV-1:0];
      m_st[c] = (m_st[c] & ~clr) | evt_i[c*NEV +: NEV];
    end
    if (wr_en && wr_op == 2'd2) m_smask = m_smask | wr_data[NCH-1:0];
    if (wr_en && wr_op == 2'd3) m_smask = m_smask & ~wr_data[NCH-1:0];
    m_sum = nsum;
    m_host = nhost;
    @(negedge clk);
    chk(32'(chan_sum_o), 32'(m_sum), {tag, " chan summary"});
    chk(32'(host_irq_o), 32'(m_host), {tag, " host irq"});
    chk(rd_status_o, m_rd, {tag, " read status"});
    chk(rd_mask_o, m_rdm, {tag, " read mask"});
  endtask

  task automatic idle();
    evt_i = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr(input logic [1:0] op, input int ch, input logic [31:0] d);
    wr_en = 1'b1; wr_op = op; wr_chan = CW'(ch); wr_data = d;
  endtask

  task automatic ev(input int ch, input int b);
    evt_i[ch*NEV + b] = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) begin m_st[c] = '0; m_mk[c] = '0; end
    m_smask = '0; m_sum = '0; m_host = 1'b0; m_rd = '0; m_rdm = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(rd_status_o, 0, "R1 status"); chk(rd_mask_o, 0, "R1 mask");
    chk(32'(chan_sum_o), 0, "R1 summary"); chk(32'(host_irq_o), 0, "R1 host");

    // R2 each event bit lands in its own position on channel 2
    rd_chan = 3'd2;
    for (int b = 0; b < NEV; b++) begin idle(); ev(2, b); step("R2"); end
    idle(); step("R2"); chk(rd_status_o, 32'h3FFF, "R2 all bits");
    // R3 clear selected bits only
    wr(2'd0, 2, 32'hFFFF_0155); step("R3"); idle(); step("R3");
    chk(rd_status_o, 32'h3EAA, "R3 partial clear");
    // R4 event beats clear on same bit
    wr(2'd0, 2, 32'h0000_0002); ev(2, 1); step("R4"); idle(); step("R4");
    chk(32'(rd_status_o[1]), 1, "R4 set wins");
    // R5 normal mode masking, R9 summary path
    wr(2'd1, 2, 32'h0000_0008); step("R5"); wr(2'd2, 0, 32'h04); step("R10");
    idle(); repeat (3) step("R5");
    chk(32'(chan_sum_o[2]), 1, "R5 irq"); chk(32'(host_irq_o), 1, "R9 host");
    wr(2'd3, 0, 32'h04); step("R10"); idle(); repeat (2) step("R10");
    chk(32'(host_irq_o), 0, "R10 summary clear");
    // R6/R8 descriptor mode: NAK recorded but silent with full mask
    rd_chan = 3'd5; desc_mode_i[5] = 1'b1;
    wr(2'd1, 5, 32'h3FFF); step("R6"); idle(); ev(5, 4); step("R8");
    idle(); repeat (2) step("R8");
    chk(32'(rd_status_o), 32'h0010, "R8 recorded"); chk(32'(chan_sum_o[5]), 0, "R6 gated");
    ev(5, 1); step("R6"); idle(); repeat (2) step("R6");
    chk(32'(chan_sum_o[5]), 1, "R6 halted passes");
    // R7 bit 12 unmaskable
    rd_chan = 3'd6; desc_mode_i[6] = 1'b1; ev(6, 12); step("R7"); idle(); repeat (2) step("R7");
    chk(32'(chan_sum_o[6]), 1, "R7 forced");
    // R11 upper bits zero
    chk(32'(rd_status_o[31:14]), 0, "R11 upper");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      idle();
      for (int c = 0; c < NCH; c++)
        evt_i[c*NEV +: NEV] = NEV'($urandom & $urandom & $urandom & $urandom);
      if (($urandom % 8) == 0) desc_mode_i = NCH'($urandom);
      rd_chan = CW'($urandom);
      if (($urandom % 2) == 0) wr(2'($urandom), int'($urandom % NCH), $urandom);
      step("R5/R6/R9 random");
    end
    idle(); step("R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule